// File: doc/BRIEF.md
# Event statistics counters with threshold interrupts

This block keeps a bank of receive and a bank of transmit event counters. Each counter is either 32 or 16 bits wide, set per counter by a parameter. Every one-cycle pulse on a counter's event input advances that counter by one. When a counter reaches the midpoint of its range, or takes an event while it holds all-ones, the counter latches its own interrupt status bit. A status bit is cleared by reading the counter's low byte lane through the register port. Each bank has a per-counter mask register. The single interrupt output is high while any status bit is set and its mask bit is clear.

A control word gives software three operations. It can clear every counter and status bit at once. It can load every counter with a value a few counts below either threshold, which makes the thresholds quick to test. It can also select whether a counter at all-ones wraps to zero or holds there. The register port is a plain word-addressed read/write port with byte enables. Read data is combinational from the address. A read takes effect on status at the clock edge that ends the read cycle.

Top module: `stat_counters_top`

## Requirements
- R1: Each cycle with a counter's event input high adds one to that counter. Counters with their width bit at 0 are 16 bits wide and read back zero-extended. Defaults: receive counters 0 and 1 and transmit counters 0 and 2 are 32 bits wide.
- R2: An event that takes a counter to 0x8000_0000 (32-bit) or 0x8000 (16-bit) sets that counter's status bit.
- R3: An event on a counter holding all-ones sets its status bit. With control bit 2 clear, the counter wraps to zero.
- R4: With control bit 2 (hold at all-ones) set, an event on a counter at all-ones leaves it at all-ones and still sets its status bit. Control bit 2 reads back as written.
- R5: A read of a counter's address with byte enable 0 high clears that counter's status bit at the end of the cycle. A read without byte enable 0 leaves the status bit unchanged.
- R6: If a threshold event and a clearing read of the same counter fall in the same cycle, the status bit stays set.
- R7: The interrupt output is the OR of all status bits whose mask bit is 0. A masked counter still sets its status bit. Mask registers take writes per byte enable, with bit k in byte lane k/8.
- R8: Writing control bit 0 as 1 (byte lane 0 enabled) clears all counters and all status bits. Control bit 0 always reads back 0.
- R9: Writing control bit 4 as 1 loads every counter with a preset value. The preset is PRESET_GAP below the half-range value when control bit 5 is 0, and PRESET_GAP below all-ones when bit 5 is 1. Bits 4 and 5 read back as written. If bit 0 is written as 1 in the same write, the counters clear instead and bit 4 reads back 0.
- R10: Word addresses: 0 control, 1 receive status, 2 transmit status, 3 receive mask, 4 transmit mask, 16+i receive counter i, 32+j transmit counter j. Status bit i belongs to counter i. Writes to the control word with byte enable 0 low are ignored. After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | NUM_RX | Receive event pulses, one per counter |
| tx_evt | input | NUM_TX | Transmit event pulses, one per counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that event inputs are single-cycle pulses that software does not need to see individually while a control write is in progress: an event that coincides with a clear or preset is dropped by design. The stimulus drives every strobe and event for exactly one cycle, starting at a falling edge. It never overlaps a read with a write. The only event it places on a clearing read is the deliberate same-cycle case.

// File: rtl/stat_pkg.sv
package stat_pkg;

  typedef struct packed {
    logic clr_all;
    logic preset_ld;
    logic preset_full;
    logic stop_roll;
  } cnt_ctrl_t;

  function automatic logic [31:0] cnt_max(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] cnt_half(input logic wide);
    return wide ? 32'h8000_0000 : 32'h0000_8000;
  endfunction

  function automatic logic [31:0] preset_val(input logic wide, input logic full,
                                             input logic [31:0] gap);
    return (full ? cnt_max(wide) : cnt_half(wide)) - gap;
  endfunction

  function automatic logic [31:0] next_count(input logic [31:0] cur, input logic wide,
                                             input logic stop);
    if (cur == cnt_max(wide)) return stop ? cur : 32'd0;
    return cur + 32'd1;
  endfunction

  function automatic logic [31:0] apply_be(input logic [31:0] old, input logic [31:0] wd,
                                           input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = be[k/8] ? wd[k] : old[k];
    return r;
  endfunction

endpackage

// File: rtl/stat_counter.sv
module stat_counter
  import stat_pkg::*;
#(
  parameter logic        WIDE       = 1'b1,
  parameter int unsigned PRESET_GAP = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cnt_ctrl_t   ctl,
  input  logic        inc,
  input  logic        rd_clr,
  output logic [31:0] value,
  output logic        status,
  output logic        hit
);
  localparam logic [31:0] MAXV     = cnt_max(WIDE);
  localparam logic [31:0] HALF_M1  = cnt_half(WIDE) - 32'd1;
  localparam logic [31:0] PRE_HALF = preset_val(WIDE, 1'b0, 32'(PRESET_GAP));
  localparam logic [31:0] PRE_FULL = preset_val(WIDE, 1'b1, 32'(PRESET_GAP));

  logic [31:0] cnt_q;
  logic        stat_q;
  logic        live_inc;

  always_comb begin
    live_inc = inc && !ctl.clr_all && !ctl.preset_ld;
    hit      = live_inc && ((cnt_q == MAXV) || (cnt_q == HALF_M1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ctl.clr_all)    cnt_q <= '0;
    else if (ctl.preset_ld)  cnt_q <= ctl.preset_full ? PRE_FULL : PRE_HALF;
    else if (live_inc)       cnt_q <= next_count(cnt_q, WIDE, ctl.stop_roll);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stat_q <= 1'b0;
    else if (ctl.clr_all) stat_q <= 1'b0;
    else if (hit)         stat_q <= 1'b1;
    else if (rd_clr)      stat_q <= 1'b0;
  end

  assign value  = cnt_q;
  assign status = stat_q;
endmodule

// File: rtl/stat_regs.sv
module stat_regs
  import stat_pkg::*;
#(
  parameter int NUM_RX = 4,
  parameter int NUM_TX = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output cnt_ctrl_t         ctl,
  output logic [31:0]       ctrl_word,
  output logic [NUM_RX-1:0] rx_mask,
  output logic [NUM_TX-1:0] tx_mask
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RXMASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TXMASK = ADDR_W'(4);

  logic ctrl_wr, stop_q, preset_q, full_q;
  logic [31:0] rx_new, tx_new;
  logic unused_wbits;

  assign ctrl_wr      = wr_en && (addr == A_CTRL) && be[0];
  assign unused_wbits = ^{wdata[31:6], wdata[3], wdata[1]};

  always_comb begin
    ctl.clr_all     = ctrl_wr && wdata[0];
    ctl.preset_ld   = ctrl_wr && !wdata[0] && wdata[4];
    ctl.preset_full = wdata[5];
    ctl.stop_roll   = stop_q;
    rx_new = apply_be(32'(rx_mask), wdata, be);
    tx_new = apply_be(32'(tx_mask), wdata, be);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      preset_q <= 1'b0;
      full_q   <= 1'b0;
    end else if (ctrl_wr) begin
      stop_q   <= wdata[2];
      preset_q <= wdata[4] && !wdata[0];
      full_q   <= wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mask <= '0;
      tx_mask <= '0;
    end else if (wr_en) begin
      if (addr == A_RXMASK) rx_mask <= rx_new[NUM_RX-1:0];
      if (addr == A_TXMASK) tx_mask <= tx_new[NUM_TX-1:0];
    end
  end

  assign ctrl_word = {26'd0, full_q, preset_q, 1'b0, stop_q, 2'b00};
endmodule

// File: rtl/stat_counters_top.sv
module stat_counters_top
  import stat_pkg::*;
#(
  parameter int                NUM_RX     = 4,
  parameter int                NUM_TX     = 4,
  parameter logic [NUM_RX-1:0] RX_WIDE    = 4'b0011,
  parameter logic [NUM_TX-1:0] TX_WIDE    = 4'b0101,
  parameter int unsigned       PRESET_GAP = 2,
  parameter int                ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_RX-1:0] rx_evt,
  input  logic [NUM_TX-1:0] tx_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int NUM_CNT = NUM_RX + NUM_TX;
  localparam int RX_BASE = 16;
  localparam int TX_BASE = 32;
  localparam logic [NUM_CNT-1:0] WIDE_ALL = {TX_WIDE, RX_WIDE};

  function automatic logic [ADDR_W-1:0] cnt_addr(input int idx);
    return (idx < NUM_RX) ? ADDR_W'(RX_BASE + idx) : ADDR_W'(TX_BASE + idx - NUM_RX);
  endfunction

  cnt_ctrl_t                    ctl;
  logic [31:0]                  ctrl_word;
  logic [NUM_RX-1:0]            rx_mask;
  logic [NUM_TX-1:0]            tx_mask;
  logic [NUM_CNT-1:0]           inc_v, rdclr_v, hit_v, stat_v, mask_v;
  logic [NUM_CNT-1:0][31:0]     val_v;
  logic                         clr_all_w, preset_ld_w, stop_roll_w;

  assign inc_v       = {tx_evt, rx_evt};
  assign mask_v      = {tx_mask, rx_mask};
  assign clr_all_w   = ctl.clr_all;
  assign preset_ld_w = ctl.preset_ld;
  assign stop_roll_w = ctl.stop_roll;

  stat_regs #(.NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
    .ctl(ctl), .ctrl_word(ctrl_word), .rx_mask(rx_mask), .tx_mask(tx_mask)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign rdclr_v[i] = rd_en && be[0] && (addr == cnt_addr(i));
    stat_counter #(.WIDE(WIDE_ALL[i]), .PRESET_GAP(PRESET_GAP)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .inc(inc_v[i]), .rd_clr(rdclr_v[i]),
      .value(val_v[i]), .status(stat_v[i]), .hit(hit_v[i])
    );
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(0): rdata = ctrl_word;
      ADDR_W'(1): rdata[NUM_RX-1:0] = stat_v[NUM_RX-1:0];
      ADDR_W'(2): rdata[NUM_TX-1:0] = stat_v[NUM_CNT-1:NUM_RX];
      ADDR_W'(3): rdata[NUM_RX-1:0] = rx_mask;
      ADDR_W'(4): rdata[NUM_TX-1:0] = tx_mask;
      default: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (addr == cnt_addr(i)) rdata = val_v[i];
      end
    endcase
  end

  assign irq = |(stat_v & ~mask_v);
endmodule

// File: rtl/stat_checker.sv
module stat_checker
  import stat_pkg::*;
#(
  parameter int           N      = 8,
  parameter logic [N-1:0] WIDE   = '1,
  parameter int           ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      inc_v,
  input logic [N-1:0]      rdclr_v,
  input logic [N-1:0]      hit_v,
  input logic [N-1:0]      stat_v,
  input logic [N-1:0][31:0] val_v,
  input logic              clr_all,
  input logic              preset_ld,
  input logic              stop_roll,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        be,
  input logic [31:0]       wdata,
  input logic [31:0]       ctrl_word
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    localparam logic [31:0] MAXV = cnt_max(WIDE[i]);

    AST_STATUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_v[i]) |-> $past(hit_v[i])); // R2
    AST_STATUS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_v[i]) |-> $past(rdclr_v[i] || clr_all)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v[i] && !clr_all && !preset_ld && !stop_roll && val_v[i] == MAXV)
      |=> (val_v[i] == 32'd0 && stat_v[i])); // R3
    AST_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v[i] && !clr_all && !preset_ld && stop_roll && val_v[i] == MAXV)
      |=> (val_v[i] == MAXV && stat_v[i])); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[i] && rdclr_v[i]) |=> stat_v[i]); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (val_v[i] == 32'd0 && !stat_v[i])); // R8
  end

  AST_RESET_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && be[0] && wdata[0]) |=> (ctrl_word[4] == 1'b0 && ctrl_word[0] == 1'b0)); // R9
endmodule

bind stat_counters_top stat_checker #(.N(NUM_CNT), .WIDE(WIDE_ALL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_v(inc_v), .rdclr_v(rdclr_v), .hit_v(hit_v),
  .stat_v(stat_v), .val_v(val_v), .clr_all(clr_all_w), .preset_ld(preset_ld_w),
  .stop_roll(stop_roll_w), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
  .ctrl_word(ctrl_word)
);

// File: tb/test_stat_counters_top.sv
module test_stat_counters_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rx_evt = '0;
  logic [3:0]  tx_evt = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_counters_top i_stat_counters_top (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  ad;
    logic [3:0]  en;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  4'hF, 32'h0,         32'h0, 4'd10}, // R10 control after reset
    '{1'b0, 6'd1,  4'hF, 32'h0,         32'h0, 4'd10}, // R10 rx status
    '{1'b0, 6'd2,  4'hF, 32'h0,         32'h0, 4'd10}, // R10 tx status
    '{1'b0, 6'd16, 4'hF, 32'h0,         32'h0, 4'd10}, // R10 rx counter 0
    '{1'b0, 6'd35, 4'hF, 32'h0,         32'h0, 4'd10}, // R10 tx counter 3
    '{1'b1, 6'd3,  4'h1, 32'hFFFF_FFF5, 32'h0, 4'd7},
    '{1'b0, 6'd3,  4'hF, 32'h0,         32'h5, 4'd7},  // R7 lane 0 written
    '{1'b1, 6'd3,  4'h0, 32'h0000_000F, 32'h0, 4'd7},
    '{1'b0, 6'd3,  4'hF, 32'h0,         32'h5, 4'd7},  // R7 no lane, no change
    '{1'b1, 6'd0,  4'h0, 32'h0000_0004, 32'h0, 4'd10},
    '{1'b0, 6'd0,  4'hF, 32'h0,         32'h0, 4'd10}, // R10 ignored without be[0]
    '{1'b1, 6'd0,  4'h1, 32'h0000_0004, 32'h0, 4'd4},
    '{1'b0, 6'd0,  4'hF, 32'h0,         32'h4, 4'd4},  // R4 bit 2 readback
    '{1'b1, 6'd0,  4'h1, 32'h0,         32'h0, 4'd4},
    '{1'b1, 6'd3,  4'h1, 32'h0,         32'h0, 4'd7},
    '{1'b0, 6'd3,  4'hF, 32'h0,         32'h0, 4'd7}   // R7 mask back to 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [3:0] e, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; be = e; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [5:0] a, input logic [3:0] e, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a; be = e;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; be = '0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [3:0] e, input string req,
                        input logic [31:0] exp);
    logic [31:0] d;
    reg_rd(a, e, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input logic [3:0] rx, input logic [3:0] tx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_evt = rx; tx_evt = tx;
      @(negedge clk);
      rx_evt = '0; tx_evt = '0;
    end
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    chk(req, 32'(irq), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_chk("R10 irq after reset", 1'b0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) reg_wr(VECS[v].ad, VECS[v].en, VECS[v].data);
      else begin
        reg_rd(VECS[v].ad, VECS[v].en, d);
        chk($sformatf("R%0d table row %0d", VECS[v].req, v), d, VECS[v].exp);
      end
    end

    // R9 preset below half
    reg_wr(6'd0, 4'h1, 32'h10);
    rd_chk(6'd0, 4'hF, "R9 preset bit readback", 32'h10);
    rd_chk(6'd16, 4'h2, "R9 32-bit half preset", 32'h7FFF_FFFE);
    rd_chk(6'd18, 4'h2, "R9 16-bit half preset", 32'h0000_7FFE);

    // R2 half threshold
    pulse(4'b0001, 4'b0000, 1);
    rd_chk(6'd16, 4'h2, "R1 one event", 32'h7FFF_FFFF);
    rd_chk(6'd1, 4'hF, "R2 below half no status", 32'h0);
    pulse(4'b0001, 4'b0000, 1);
    rd_chk(6'd1, 4'hF, "R2 half reached", 32'h1);
    irq_chk("R2 irq raised", 1'b1);

    // R5 clear only through byte lane 0
    rd_chk(6'd16, 4'h2, "R5 value at half", 32'h8000_0000);
    rd_chk(6'd1, 4'hF, "R5 no clear without lane 0", 32'h1);
    rd_chk(6'd16, 4'h1, "R5 clearing read value", 32'h8000_0000);
    rd_chk(6'd1, 4'hF, "R5 status cleared", 32'h0);
    irq_chk("R5 irq dropped", 1'b0);

    // R7 masked source still latches
    reg_wr(6'd3, 4'h1, 32'h4);
    pulse(4'b0100, 4'b0000, 2);
    rd_chk(6'd1, 4'hF, "R7 masked status set", 32'h4);
    irq_chk("R7 masked irq low", 1'b0);
    reg_wr(6'd3, 4'h1, 32'h0);
    irq_chk("R7 unmasked irq high", 1'b1);
    rd_chk(6'd18, 4'h1, "R2 16-bit half value", 32'h0000_8000);
    irq_chk("R5 irq low after read", 1'b0);

    // R3 16-bit wrap
    reg_wr(6'd0, 4'h1, 32'h30);
    rd_chk(6'd32, 4'h2, "R9 32-bit full preset", 32'hFFFF_FFFD);
    rd_chk(6'd33, 4'h2, "R9 16-bit full preset", 32'h0000_FFFD);
    pulse(4'b0000, 4'b0010, 2);
    rd_chk(6'd2, 4'hF, "R3 at max no status", 32'h0);
    pulse(4'b0000, 4'b0010, 1);
    rd_chk(6'd2, 4'hF, "R3 crossing status", 32'h2);
    irq_chk("R3 irq", 1'b1);
    rd_chk(6'd33, 4'h1, "R3 wrapped to zero", 32'h0);
    rd_chk(6'd2, 4'hF, "R5 tx status cleared", 32'h0);

    // R4 hold at all-ones
    reg_wr(6'd0, 4'h1, 32'h34);
    pulse(4'b0001, 4'b0000, 3);
    rd_chk(6'd1, 4'hF, "R4 status on hold", 32'h1);
    rd_chk(6'd16, 4'h1, "R4 held at max", 32'hFFFF_FFFF);
    rd_chk(6'd1, 4'hF, "R4 status cleared", 32'h0);

    // R6 same-cycle set versus clear
    pulse(4'b1000, 4'b0000, 2);
    @(negedge clk);
    rx_evt = 4'b1000; rd_en = 1'b1; addr = 6'd19; be = 4'h1;
    @(negedge clk);
    rx_evt = '0; rd_en = 1'b0; be = '0;
    rd_chk(6'd1, 4'hF, "R6 set wins over clear", 32'h8);
    rd_chk(6'd19, 4'h1, "R6 value held", 32'h0000_FFFF);
    rd_chk(6'd1, 4'hF, "R6 later read clears", 32'h0);

    // R8 and R9 reset over preset
    pulse(4'b0001, 4'b0000, 1);
    rd_chk(6'd1, 4'hF, "R8 status before reset", 32'h1);
    reg_wr(6'd0, 4'h1, 32'h11);
    rd_chk(6'd0, 4'hF, "R9 preset not set with reset", 32'h0);
    rd_chk(6'd16, 4'h2, "R8 counter cleared", 32'h0);
    rd_chk(6'd33, 4'h2, "R8 tx counter cleared", 32'h0);
    rd_chk(6'd1, 4'hF, "R8 status cleared", 32'h0);
    irq_chk("R8 irq low", 1'b0);

    // R1 counting from zero
    pulse(4'b0010, 4'b0001, 3);
    rd_chk(6'd17, 4'h2, "R1 rx1 count", 32'd3);
    rd_chk(6'd32, 4'h2, "R1 tx0 count", 32'd3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule